// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block controls a port of general-purpose pins through a small register window. Each pin attribute has its own register set: one write-only register that turns bits on, one that turns bits off, and a read-only register that shows the current state. Because of this, software can change any group of bits with a single write and never needs a read-modify-write. The attributes are:

- GPIO ownership versus peripheral ownership
- output enable
- input glitch filter
- interrupt mask
- multi-driver (open-drain)
- pull-up
- choice between peripheral A and peripheral B
- an unlock mask for direct writes to the output data

The output level is changed through separate set and clear registers. The output data register can also be written directly, but only in the bits that the unlock mask allows.

Incoming pad levels pass through a two-flop synchronizer. An optional per-bit glitch filter follows it. The block then detects level changes. A detected change latches a bit in an interrupt status register, which is cleared when it is read. The interrupt line is raised when a latched bit is also enabled in the interrupt mask.

On the pad side, each pin is driven by one of three sources: the GPIO output data, peripheral A or peripheral B. A pin in multi-driver mode only ever pulls low.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, the status registers read as follows. Ownership (0x08) and pull-up (0x68) read all ones. Output enable (0x18), filter (0x28), output data (0x38), interrupt mask (0x48), interrupt status (0x4C), multi-driver (0x58), peripheral select (0x78) and output-write unlock (0xA8) read zero.
- R2: A write of ones sets the matching status bits through the set register of each attribute, and clears them through the clear register of each attribute. Bits written as zero keep their value.
  - Set / clear / status offsets: ownership 0x00 / 0x04 / 0x08; output enable 0x10 / 0x14 / 0x18; filter 0x20 / 0x24 / 0x28; interrupt mask 0x40 / 0x44 / 0x48; multi-driver 0x50 / 0x54 / 0x58; output-write unlock 0xA0 / 0xA4 / 0xA8.
  - Pull-up is cleared at 0x60, set at 0x64 and read at 0x68.
  - Peripheral select: 0x70 selects A (clears the bit), 0x74 selects B (sets the bit), and 0x78 reads it.
- R3: Writing ones to 0x30 sets output data bits, and writing ones to 0x34 clears them. The result reads at 0x38.
- R4: A direct write to 0x38 changes only the bits whose output-write unlock bit is 1. All other bits keep their value.
- R5: Reads of write-only offsets, of unused offsets and of offsets that are not word aligned return zero.
- R6: With the filter off, a pad change appears at offset 0x3C after three rising clock edges.
- R7: With the filter on for a bit, a pulse that lasts one clock never reaches offset 0x3C. A steady change reaches it after four rising edges.
- R8: A change of a bit at 0x3C sets that bit in the interrupt status at 0x4C. A read of 0x4C (bus_rd high) returns the status and clears it. A change in the same cycle as the read stays latched.
- R9: irq is high exactly when some interrupt status bit is 1 and its mask bit is 1.
- R10: A pin owned by GPIO drives the output data and the output enable. A pin owned by a peripheral takes its data and enable from peripheral A when its select bit is 0, and from peripheral B when its select bit is 1.
- R11: A pin in multi-driver mode has pad_out at 0 and pad_oe equal to the inverse of its data, whatever the output enable says.
- R12: pad_pu follows the pull-up status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational from bus_addr |
| pin_in | input | W (32) | Pad input levels, asynchronous |
| pad_out | output | W (32) | Pad output data |
| pad_oe | output | W (32) | Pad output enable |
| pad_pu | output | W (32) | Pad pull-up enable |
| pera_out | input | W (32) | Peripheral A data |
| pera_oe | input | W (32) | Peripheral A enable |
| perb_out | input | W (32) | Peripheral B data |
| perb_oe | input | W (32) | Peripheral B enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins, and ownership and pull-up both resetting to all ones. At this width the vectors can use patterns that touch the top bit and the upper half of every register, including the all-ones direct write that R4 must partly reject. With the same default reset values, a second reset brings the pad outputs back to a known state before the directed tests. Those tests then exercise the synchronizer latency, the filter, the clear-on-read behaviour and the pad muxing.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int ADDR_W = 8;

    // Register offsets; the set/clear/status grouping is what software relies on
    localparam logic [ADDR_W-1:0] OFF_OWN_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_OWN_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_OWN_STS = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_OE_SET  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_OE_CLR  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_OE_STS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_FLT_SET = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_FLT_CLR = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_FLT_STS = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_OD_SET  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_OD_CLR  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_OD_STS  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_LVL     = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_IMR_SET = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_IMR_CLR = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_IMR_STS = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_ISR     = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_MD_SET  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_MD_CLR  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_MD_STS  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_PU_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_PU_SET  = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_PU_STS  = 8'h68;
    localparam logic [ADDR_W-1:0] OFF_SELA    = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_SELB    = 8'h74;
    localparam logic [ADDR_W-1:0] OFF_SEL_STS = 8'h78;
    localparam logic [ADDR_W-1:0] OFF_OWE_SET = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_OWE_CLR = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_OWE_STS = 8'hA8;

    // Kind of update an attribute register receives in one cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_LOAD = 2'd3
    } acc_e;

    // One update command per attribute, produced by the write decoder
    typedef struct packed {
        acc_e own;
        acc_e oe;
        acc_e flt;
        acc_e od;
        acc_e imr;
        acc_e md;
        acc_e pu;
        acc_e sel;
        acc_e owe;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_write(input logic wr, input logic [ADDR_W-1:0] a);
        reg_cmd_t c;
        c = '0;
        if (wr) begin
            case (a)
                OFF_OWN_SET: c.own = ACC_SET;
                OFF_OWN_CLR: c.own = ACC_CLR;
                OFF_OE_SET:  c.oe  = ACC_SET;
                OFF_OE_CLR:  c.oe  = ACC_CLR;
                OFF_FLT_SET: c.flt = ACC_SET;
                OFF_FLT_CLR: c.flt = ACC_CLR;
                OFF_OD_SET:  c.od  = ACC_SET;
                OFF_OD_CLR:  c.od  = ACC_CLR;
                OFF_OD_STS:  c.od  = ACC_LOAD;
                OFF_IMR_SET: c.imr = ACC_SET;
                OFF_IMR_CLR: c.imr = ACC_CLR;
                OFF_MD_SET:  c.md  = ACC_SET;
                OFF_MD_CLR:  c.md  = ACC_CLR;
                OFF_PU_SET:  c.pu  = ACC_SET;
                OFF_PU_CLR:  c.pu  = ACC_CLR;
                OFF_SELB:    c.sel = ACC_SET;
                OFF_SELA:    c.sel = ACC_CLR;
                OFF_OWE_SET: c.owe = ACC_SET;
                OFF_OWE_CLR: c.owe = ACC_CLR;
                default:     c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/gpio_sc_cell.sv
module gpio_sc_cell
    import gpio_sc_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_e         cmd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lmask,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST;
        end else begin
            case (cmd)
                ACC_SET:  q <= q | wdata;
                ACC_CLR:  q <= q & ~wdata;
                ACC_LOAD: q <= (q & ~lmask) | (wdata & lmask);
                default:  q <= q;
            endcase
        end
    end

    AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd == ACC_SET) |=> (($past(q) & ~q) == '0)); // R2

    AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (cmd == ACC_CLR) |=> ((~$past(q) & q) == '0)); // R2

    AST_LOAD_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cmd == ACC_LOAD) |=> (((q ^ $past(q)) & ~$past(lmask)) == '0)); // R4

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] flt,
    output logic [W-1:0] level,
    output logic [W-1:0] chg
);

    logic [W-1:0] s1, s2, s2d;
    logic [W-1:0] level_nxt;

    // Filtered bits accept s2 only once it has matched its delayed copy
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (flt[i]) begin
                level_nxt[i] = (s2[i] == s2d[i]) ? s2[i] : level[i];
            end else begin
                level_nxt[i] = s2[i];
            end
        end
    end

    assign chg = level_nxt ^ level;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= '0;
            s2    <= '0;
            s2d   <= '0;
            level <= '0;
        end else begin
            s1    <= pin_in;
            s2    <= s1;
            s2d   <= s2;
            level <= level_nxt;
        end
    end

    AST_FILTER_STEADY: assert property (@(posedge clk) disable iff (rst)
        (((level ^ $past(level)) & $past(flt) & (level ^ $past(s2d))) == '0)); // R7

endmodule

// File: rtl/gpio_sc_drive.sv
module gpio_sc_drive #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] own,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] odata,
    input  logic [W-1:0] md,
    input  logic [W-1:0] pera_out,
    input  logic [W-1:0] pera_oe,
    input  logic [W-1:0] perb_out,
    input  logic [W-1:0] perb_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic src_d, src_e;
        always_comb begin
            if (own[i]) begin
                src_d = odata[i];
                src_e = oe[i];
            end else if (sel[i]) begin
                src_d = perb_out[i];
                src_e = perb_oe[i];
            end else begin
                src_d = pera_out[i];
                src_e = pera_oe[i];
            end
            if (md[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = ~src_d;
            end else begin
                pad_out[i] = src_d;
                pad_oe[i]  = src_e;
            end
        end
    end

    AST_MD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & pad_oe & md) == '0)); // R11

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int           W       = 32,
    parameter logic [W-1:0] OWN_RST = '1,
    parameter logic [W-1:0] PU_RST  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu,
    input  logic [W-1:0]      pera_out,
    input  logic [W-1:0]      pera_oe,
    input  logic [W-1:0]      perb_out,
    input  logic [W-1:0]      perb_oe,
    output logic              irq
);

    localparam logic [W-1:0] ZERO = '0;

    reg_cmd_t     cmd;
    logic [W-1:0] own_q, oe_q, flt_q, od_q, imr_q, md_q, pu_q, sel_q, owe_q;
    logic [W-1:0] level, chg, isr_q;
    logic         isr_rd;

    assign cmd    = decode_write(bus_wr, bus_addr);
    assign isr_rd = bus_rd && (bus_addr == OFF_ISR);

    gpio_sc_cell #(.W(W), .RST(OWN_RST)) u_own (.clk(clk), .rst(rst), .cmd(cmd.own),
        .wdata(bus_wdata), .lmask(ZERO), .q(own_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_oe (.clk(clk), .rst(rst), .cmd(cmd.oe),
        .wdata(bus_wdata), .lmask(ZERO), .q(oe_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_flt (.clk(clk), .rst(rst), .cmd(cmd.flt),
        .wdata(bus_wdata), .lmask(ZERO), .q(flt_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_od (.clk(clk), .rst(rst), .cmd(cmd.od),
        .wdata(bus_wdata), .lmask(owe_q), .q(od_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_imr (.clk(clk), .rst(rst), .cmd(cmd.imr),
        .wdata(bus_wdata), .lmask(ZERO), .q(imr_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_md (.clk(clk), .rst(rst), .cmd(cmd.md),
        .wdata(bus_wdata), .lmask(ZERO), .q(md_q));
    gpio_sc_cell #(.W(W), .RST(PU_RST)) u_pu (.clk(clk), .rst(rst), .cmd(cmd.pu),
        .wdata(bus_wdata), .lmask(ZERO), .q(pu_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_sel (.clk(clk), .rst(rst), .cmd(cmd.sel),
        .wdata(bus_wdata), .lmask(ZERO), .q(sel_q));
    gpio_sc_cell #(.W(W), .RST(ZERO)) u_owe (.clk(clk), .rst(rst), .cmd(cmd.owe),
        .wdata(bus_wdata), .lmask(ZERO), .q(owe_q));

    gpio_sc_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .flt(flt_q),
        .level(level), .chg(chg)
    );

    gpio_sc_drive #(.W(W)) u_drive (
        .clk(clk), .rst(rst), .own(own_q), .sel(sel_q), .oe(oe_q), .odata(od_q),
        .md(md_q), .pera_out(pera_out), .pera_oe(pera_oe), .perb_out(perb_out),
        .perb_oe(perb_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Interrupt status: a fresh change always wins over the clearing read
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else if (isr_rd) begin
            isr_q <= chg;
        end else begin
            isr_q <= isr_q | chg;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_OWN_STS: bus_rdata = own_q;
            OFF_OE_STS:  bus_rdata = oe_q;
            OFF_FLT_STS: bus_rdata = flt_q;
            OFF_OD_STS:  bus_rdata = od_q;
            OFF_LVL:     bus_rdata = level;
            OFF_IMR_STS: bus_rdata = imr_q;
            OFF_ISR:     bus_rdata = isr_q;
            OFF_MD_STS:  bus_rdata = md_q;
            OFF_PU_STS:  bus_rdata = pu_q;
            OFF_SEL_STS: bus_rdata = sel_q;
            OFF_OWE_STS: bus_rdata = owe_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign pad_pu = pu_q;
    assign irq    = |(isr_q & imr_q);

    AST_CHANGE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (|chg) |=> ((isr_q & $past(chg)) == $past(chg))); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && (chg == '0)) |=> (isr_q == '0)); // R8

    AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (imr_q == '0) |-> !irq); // R9

    AST_MISALIGNED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R5

endmodule

// File: tb/tb_gpio_sc_port.sv
`timescale 1ns/1ps
module tb_gpio_sc_port;

    localparam int W  = 32;
    localparam int NV = 48;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr, bus_rd;
    logic [7:0]   bus_addr;
    logic [W-1:0] bus_wdata, bus_rdata;
    logic [W-1:0] pin_in, pad_out, pad_oe, pad_pu;
    logic [W-1:0] pera_out, pera_oe, perb_out, perb_oe;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_sc_port #(.W(W)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pera_out(pera_out), .pera_oe(pera_oe), .perb_out(perb_out),
        .perb_oe(perb_oe), .irq(irq)
    );

    // {is_write, offset, data}: writes apply data, reads compare against data
    localparam logic [40:0] VEC [0:NV-1] = '{
        {1'b0, 8'h08, 32'hFFFFFFFF},  // R1
        {1'b0, 8'h18, 32'h00000000},  // R1
        {1'b0, 8'h28, 32'h00000000},  // R1
        {1'b0, 8'h38, 32'h00000000},  // R1
        {1'b0, 8'h48, 32'h00000000},  // R1
        {1'b0, 8'h4C, 32'h00000000},  // R1
        {1'b0, 8'h58, 32'h00000000},  // R1
        {1'b0, 8'h68, 32'hFFFFFFFF},  // R1
        {1'b0, 8'h78, 32'h00000000},  // R1
        {1'b0, 8'hA8, 32'h00000000},  // R1
        {1'b1, 8'h04, 32'h8000000F},  // R2
        {1'b0, 8'h08, 32'h7FFFFFF0},  // R2
        {1'b1, 8'h00, 32'h00000001},  // R2
        {1'b0, 8'h08, 32'h7FFFFFF1},  // R2
        {1'b1, 8'h04, 32'h00000000},  // R2 zero bits
        {1'b0, 8'h08, 32'h7FFFFFF1},  // R2
        {1'b1, 8'h10, 32'h800000F0},  // R2
        {1'b1, 8'h14, 32'h00000030},  // R2
        {1'b0, 8'h18, 32'h800000C0},  // R2
        {1'b1, 8'h30, 32'h8000FF00},  // R3
        {1'b1, 8'h34, 32'h0000F000},  // R3
        {1'b0, 8'h38, 32'h80000F00},  // R3
        {1'b1, 8'h38, 32'hFFFFFFFF},  // R4 all locked
        {1'b0, 8'h38, 32'h80000F00},  // R4
        {1'b1, 8'hA0, 32'h000000FF},  // R2
        {1'b0, 8'hA8, 32'h000000FF},  // R2
        {1'b1, 8'h38, 32'h12345678},  // R4 low byte unlocked
        {1'b0, 8'h38, 32'h80000F78},  // R4
        {1'b1, 8'hA4, 32'h000000FF},  // R2
        {1'b0, 8'hA8, 32'h00000000},  // R2
        {1'b0, 8'h00, 32'h00000000},  // R5 write-only
        {1'b0, 8'h30, 32'h00000000},  // R5 write-only
        {1'b0, 8'h44, 32'h00000000},  // R5 write-only
        {1'b0, 8'h1C, 32'h00000000},  // R5 unused
        {1'b0, 8'h3A, 32'h00000000},  // R5 misaligned
        {1'b1, 8'h50, 32'h00000003},  // R2
        {1'b1, 8'h54, 32'h00000001},  // R2
        {1'b0, 8'h58, 32'h00000002},  // R2
        {1'b1, 8'h60, 32'hFFFF0000},  // R2 pull-up off
        {1'b0, 8'h68, 32'h0000FFFF},  // R2
        {1'b1, 8'h74, 32'h00000006},  // R2 select B
        {1'b1, 8'h70, 32'h00000002},  // R2 select A
        {1'b0, 8'h78, 32'h00000004},  // R2
        {1'b1, 8'h40, 32'h00000005},  // R2
        {1'b1, 8'h44, 32'h00000004},  // R2
        {1'b0, 8'h48, 32'h00000001},  // R2
        {1'b1, 8'h20, 32'hC0000000},  // R2
        {1'b0, 8'h28, 32'hC0000000}   // R2
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] r;
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_in = '0;
        pera_out = 32'h00AA0000; pera_oe = 32'h00F00000;
        perb_out = 32'h00550000; perb_oe = 32'h000F0000;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) begin
                bus_write(VEC[i][39:32], VEC[i][31:0]);
            end else begin
                peek(VEC[i][39:32], r);
                chk($sformatf("R1-R5 table vector %0d offset %h", i, VEC[i][39:32]),
                    r, VEC[i][31:0]);
            end
        end

        // R1: pad side after a fresh reset
        do_reset();
        #1;
        chk("R1 pad_out after reset", pad_out, '0);
        chk("R1 pad_oe after reset", pad_oe, '0);
        chk("R1 irq after reset", {31'b0, irq}, '0);
        chk("R12 pad_pu after reset", pad_pu, 32'hFFFFFFFF);

        // R10: GPIO-owned pins drive the output data
        bus_write(8'h10, 32'h000000FF);
        bus_write(8'h30, 32'h000000A5);
        #1;
        chk("R10 gpio pad_out", pad_out, 32'h000000A5);
        chk("R10 gpio pad_oe", pad_oe, 32'h000000FF);

        // R11: multi-driver pins only pull low, whatever the output enable
        bus_write(8'h50, 32'h00000103);
        #1;
        chk("R11 md pad_out", pad_out, 32'h000000A4);
        chk("R11 md pad_oe", pad_oe, 32'h000001FE);

        // R10: peripheral ownership, A then B
        bus_write(8'h04, 32'h00FF0000);
        #1;
        chk("R10 periph A out", pad_out & 32'h00FF0000, 32'h00AA0000);
        chk("R10 periph A oe", pad_oe & 32'h00FF0000, 32'h00F00000);
        bus_write(8'h74, 32'h00FF0000);
        #1;
        chk("R10 periph B out", pad_out & 32'h00FF0000, 32'h00550000);
        chk("R10 periph B oe", pad_oe & 32'h00FF0000, 32'h000F0000);

        // R12: pull-up follows its status
        bus_write(8'h60, 32'h00000001);
        #1;
        chk("R12 pad_pu after disable", pad_pu, 32'hFFFFFFFE);

        // R6: three-edge latency with the filter off
        @(negedge clk);
        pin_in = 32'h00000010;
        repeat (2) @(negedge clk);
        peek(8'h3C, r);
        chk("R6 level after two edges", r, 32'h00000000);
        @(negedge clk);
        peek(8'h3C, r);
        chk("R6 level after three edges", r, 32'h00000010);

        // R8/R9: latched change, mask, clear on read
        chk("R9 irq low while masked", {31'b0, irq}, '0);
        bus_write(8'h40, 32'h00000010);
        #1;
        chk("R9 irq high when unmasked", {31'b0, irq}, 32'h1);
        bus_read(8'h4C, r);
        chk("R8 status read value", r, 32'h00000010);
        peek(8'h4C, r);
        chk("R8 status after read", r, 32'h00000000);
        chk("R9 irq after clear", {31'b0, irq}, '0);

        // R7: filter rejects a one-clock pulse, passes a steady change late
        bus_write(8'h20, 32'h00000001);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        pin_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        peek(8'h3C, r);
        chk("R7 pulse filtered level", r & 32'h1, 32'h0);
        peek(8'h4C, r);
        chk("R7 pulse filtered status", r, 32'h0);
        pin_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        peek(8'h3C, r);
        chk("R7 level after three edges", r & 32'h1, 32'h0);
        @(negedge clk);
        peek(8'h3C, r);
        chk("R7 level after four edges", r & 32'h1, 32'h1);

        finish_run();
    end

endmodule